// File: doc/BRIEF.md
# Machine-Check Error Reporting Bank

This block is one error-reporting bank of a machine-check subsystem. Up to `NUM_SRC` hardware error sources can each raise a request. Every request carries three things: a 16-bit architectural error code, a 16-bit model-specific error code and a flag that marks the error as corrected.

A 64-bit control word holds one reporting-enable bit per source. Among the enabled requesters, the lowest-numbered one is captured into a 64-bit status word and the valid flag is set. Once the status word is valid it keeps its first event. Later corrected events only advance a saturating 15-bit counter. Software reads and writes both words through a single register port. The status word can only be cleared by writing all zeros to it. Any other write to it is refused and raises a one-cycle fault output.

Static capability inputs choose how bits 56:32 of the status word are laid out. These bits can show the corrected-error counter, two bits of threshold-based status, and a flag that says firmware may have edited the word. When a capability is off, the matching bits carry implementation-specific information that the event supplies. A legacy mode restricts control writes to all-ones or all-zeros.

Top module: `mc_err_bank`

## Requirements
- R1: After reset, the control word reads 0, the status word reads 0 and `wr_fault` is low.
- R2: An enabled event sets status bit 63 (valid), puts the source's architectural code in bits 15:0 and its model-specific code in bits 31:16, and keeps bits 62:57 at zero.
- R3: A status write (`reg_sel`=1) with a nonzero value leaves the status word unchanged and drives `wr_fault` high for exactly the next cycle.
- R4: A status write of zero clears the status word and the corrected counter, and does not raise `wr_fault`.
- R5: Control bit j enables source j. A request from a source whose control bit is 0 logs nothing.
- R6: With `legacy_ctl`=0, any value written to the control word (`reg_sel`=0) is stored. With `legacy_ctl`=1, only all-zeros or all-ones is stored, and any other value leaves the control word unchanged.
- R7: With `cap_cnt`=1, status bits 52:38 show the corrected-error count. With `cap_cnt`=0, they show `evt_info[20:6]` of the captured event.
- R8: With `cap_thr`=1 and `cap_ext`=0, bits 54:53 show `evt_thr` and bits 56:55 read 0. With `cap_thr`=1 and `cap_ext`=1, bits 56:55 show `evt_info[24:23]`. With `cap_thr`=0, bits 56:53 show `evt_info[24:21]`.
- R9: With `cap_fw`=1, bit 37 shows `evt_fw`. With `cap_fw`=0, bit 37 shows `evt_info[5]`. Bits 36:32 always show `evt_info[4:0]`.
- R10: While the valid flag is set, later events keep the first captured fields. Each cycle whose selected source has its corrected flag set adds 1 to the counter, and the counter saturates at 32767.
- R11: If an event and a clearing write happen in the same cycle, the status word ends up valid and holds the new event, with the counter restarted from that event.
- R12: When several enabled sources request in the same cycle, the lowest-numbered one is captured.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cap_cnt | input | 1 | Corrected-counter layout capability |
| cap_thr | input | 1 | Threshold-status layout capability |
| cap_ext | input | 1 | Extended upper layout capability |
| cap_fw | input | 1 | Firmware-edited flag capability |
| legacy_ctl | input | 1 | Restrict control writes to all-zeros or all-ones |
| src_req | input | NUM_SRC | Per-source error request |
| src_corr | input | NUM_SRC | Per-source corrected-error flag |
| src_arch | input | NUM_SRC*16 | Per-source architectural code, source k in bits 16k+15:16k |
| src_model | input | NUM_SRC*16 | Per-source model-specific code, same packing |
| evt_info | input | 25 | Implementation-specific information for status bits 56:32 |
| evt_thr | input | 2 | Threshold-based status of the event |
| evt_fw | input | 1 | Firmware-edited indication of the event |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 selects control, 1 selects status |
| reg_wdata | input | 64 | Register write data |
| reg_rdata | output | 64 | Read data of the selected register |
| wr_fault | output | 1 | Protection fault from a refused status write |

## Verification
Two sweeps run over all 64 sources. In the first, every source requests while only one control bit is set, which separates a failing enable mask from a failing code mux. In the second, all control bits are set and the requesters run from j to 63, which exposes any priority other than lowest-index. All sixteen combinations of the four capability inputs are run with a single fixed information pattern, and each expected word is worked out field by field, so a misplaced or mis-gated field in bits 56:32 shows up. A long run of corrected events checks counter saturation. Directed sequences cover the first-event-sticks rule, the refused nonzero write, the legacy filter and a clear that collides with an event.

// File: rtl/mc_bank_pkg.sv
// Package: shared constants and types for the error reporting bank.
// Assumes a 64-bit register layout with the variable field at bits 56:32.
package mc_bank_pkg;
    localparam int unsigned REG_W     = 64;
    localparam int unsigned CODE_W    = 16;
    localparam int unsigned INFO_W    = 25;
    localparam int unsigned CNT_W     = 15;
    localparam int unsigned VALID_BIT = 63;
    localparam int unsigned UPPER_LSB = 32;
    localparam int unsigned FW_BIT    = 37;
    localparam int unsigned CNT_LSB   = 38;
    localparam int unsigned THR_LSB   = 53;
    localparam int unsigned EXT_LSB   = 55;
    // Positions inside the 25-bit variable field
    localparam int unsigned FW_REL    = FW_BIT  - UPPER_LSB;
    localparam int unsigned CNT_REL   = CNT_LSB - UPPER_LSB;
    localparam int unsigned THR_REL   = THR_LSB - UPPER_LSB;
    localparam int unsigned EXT_REL   = EXT_LSB - UPPER_LSB;
    localparam int unsigned PAD_W     = VALID_BIT - (UPPER_LSB + INFO_W);

    typedef enum logic {
        SEL_CTL = 1'b0,
        SEL_STS = 1'b1
    } reg_sel_e;

    typedef struct packed {
        logic [CODE_W-1:0] model;
        logic [CODE_W-1:0] arch;
    } mc_code_t;
endpackage

// File: rtl/mc_src_arbiter.sv
// Module: picks the lowest-index source that requests and is enabled, and
// muxes out its codes and corrected flag. Purely combinational.
// Assumes: source k's codes sit at bits k*CODE_W +: CODE_W of each bus.
module mc_src_arbiter #(
    parameter int unsigned NUM_SRC = 64,
    parameter int unsigned CODE_W  = 16
) (
    input  logic [NUM_SRC-1:0]        req,
    input  logic [NUM_SRC-1:0]        en,
    input  logic [NUM_SRC-1:0]        corr,
    input  logic [NUM_SRC*CODE_W-1:0] arch_bus,
    input  logic [NUM_SRC*CODE_W-1:0] model_bus,
    output logic                      fire,
    output logic [NUM_SRC-1:0]        grant,
    output logic [CODE_W-1:0]         arch,
    output logic [CODE_W-1:0]         model,
    output logic                      corr_sel
);
    logic [NUM_SRC-1:0] live;
    logic [CODE_W-1:0]  arch_m  [NUM_SRC];
    logic [CODE_W-1:0]  model_m [NUM_SRC];

    assign live     = req & en;
    assign grant    = live & (~live + NUM_SRC'(1));
    assign fire     = |live;
    assign corr_sel = |(grant & corr);

    // Per-source masking of the code buses by the grant vector
    for (genvar g = 0; g < NUM_SRC; g++) begin : g_mask
        assign arch_m[g]  = {CODE_W{grant[g]}} & arch_bus[g*CODE_W +: CODE_W];
        assign model_m[g] = {CODE_W{grant[g]}} & model_bus[g*CODE_W +: CODE_W];
    end

    // OR-reduce the masked codes into the selected pair
    always_comb begin
        arch  = '0;
        model = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            arch  = arch  | arch_m[i];
            model = model | model_m[i];
        end
    end
endmodule

// File: rtl/mc_ctl_reg.sv
// Module: per-source reporting-enable register with an optional legacy
// filter that only accepts all-zeros or all-ones writes.
// Assumes: synchronous active-low reset; legacy is static during writes.
module mc_ctl_reg #(
    parameter int unsigned NUM_SRC = 64
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               we,
    input  logic               legacy,
    input  logic [NUM_SRC-1:0] wdata,
    output logic [NUM_SRC-1:0] ctl
);
    logic accept;

    // Decide whether the incoming write is allowed to land
    always_comb begin
        accept = we && (!legacy || (wdata == '0) || (wdata == '1));
    end

    // Hold the enable bits
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl <= '0;
        end else if (accept) begin
            ctl <= wdata;
        end
    end

    // R6: a mixed value written in legacy mode is dropped
    a_r6_legacy_filter: assert property (@(posedge clk) disable iff (!rst_n)
        (we && legacy && (wdata != '0) && (wdata != '1)) |=> $stable(ctl));
endmodule

// File: rtl/mc_status_fmt.sv
// Module: shapes the variable field (status bits 56:32) from the capability
// inputs, once when an event is captured and once more on read to overlay
// the live corrected-error count.
// Assumes: capability inputs are static while the status word is valid.
module mc_status_fmt
    import mc_bank_pkg::*;
(
    input  logic              cap_cnt,
    input  logic              cap_thr,
    input  logic              cap_ext,
    input  logic              cap_fw,
    input  logic [INFO_W-1:0] evt_info,
    input  logic [1:0]        evt_thr,
    input  logic              evt_fw,
    input  logic [INFO_W-1:0] held_info,
    input  logic [CNT_W-1:0]  held_cnt,
    output logic [INFO_W-1:0] cap_field,
    output logic [INFO_W-1:0] rd_field
);
    // Build the field stored at capture time
    always_comb begin
        cap_field = evt_info;
        if (cap_fw) begin
            cap_field[FW_REL] = evt_fw;
        end
        if (cap_thr) begin
            cap_field[THR_REL +: 2] = evt_thr;
            if (!cap_ext) begin
                cap_field[EXT_REL +: 2] = 2'b00;
            end
        end
    end

    // Overlay the live counter for reads
    always_comb begin
        rd_field = held_info;
        if (cap_cnt) begin
            rd_field[CNT_REL +: CNT_W] = held_cnt;
        end
    end
endmodule

// File: rtl/mc_err_bank.sv
// Module: top of one machine-check reporting bank. It holds the status word,
// applies the software clear and refused-write rules, and drives the read mux.
// Assumes: NUM_SRC <= 64; one register access per cycle; reg_sel 0 = control,
// 1 = status.
module mc_err_bank
    import mc_bank_pkg::*;
#(
    parameter int unsigned NUM_SRC = 64
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      cap_cnt,
    input  logic                      cap_thr,
    input  logic                      cap_ext,
    input  logic                      cap_fw,
    input  logic                      legacy_ctl,
    input  logic [NUM_SRC-1:0]        src_req,
    input  logic [NUM_SRC-1:0]        src_corr,
    input  logic [NUM_SRC*CODE_W-1:0] src_arch,
    input  logic [NUM_SRC*CODE_W-1:0] src_model,
    input  logic [INFO_W-1:0]         evt_info,
    input  logic [1:0]                evt_thr,
    input  logic                      evt_fw,
    input  logic                      reg_we,
    input  logic                      reg_sel,
    input  logic [REG_W-1:0]          reg_wdata,
    output logic [REG_W-1:0]          reg_rdata,
    output logic                      wr_fault
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [NUM_SRC-1:0] ctl;
    logic [NUM_SRC-1:0] grant;
    logic               fire;
    logic               corr_sel;
    logic [CODE_W-1:0]  sel_arch;
    logic [CODE_W-1:0]  sel_model;
    logic [INFO_W-1:0]  cap_field;
    logic [INFO_W-1:0]  rd_field;
    logic               sts_valid;
    mc_code_t           sts_code;
    logic [INFO_W-1:0]  sts_info;
    logic [CNT_W-1:0]   sts_cnt;
    logic               fault_q;
    logic               ctl_we;
    logic               sts_we;
    logic               sts_clr;
    logic               sts_bad;
    logic               keep_valid;

    // Decode the register port into control and status actions
    always_comb begin
        ctl_we     = reg_we && (reg_sel == SEL_CTL);
        sts_we     = reg_we && (reg_sel == SEL_STS);
        sts_clr    = sts_we && (reg_wdata == '0);
        sts_bad    = sts_we && (reg_wdata != '0);
        keep_valid = sts_valid && !sts_clr;
    end

    mc_ctl_reg #(.NUM_SRC(NUM_SRC)) u_ctl (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (ctl_we),
        .legacy (legacy_ctl),
        .wdata  (reg_wdata[NUM_SRC-1:0]),
        .ctl    (ctl)
    );

    mc_src_arbiter #(.NUM_SRC(NUM_SRC), .CODE_W(CODE_W)) u_arb (
        .req       (src_req),
        .en        (ctl),
        .corr      (src_corr),
        .arch_bus  (src_arch),
        .model_bus (src_model),
        .fire      (fire),
        .grant     (grant),
        .arch      (sel_arch),
        .model     (sel_model),
        .corr_sel  (corr_sel)
    );

    mc_status_fmt u_fmt (
        .cap_cnt   (cap_cnt),
        .cap_thr   (cap_thr),
        .cap_ext   (cap_ext),
        .cap_fw    (cap_fw),
        .evt_info  (evt_info),
        .evt_thr   (evt_thr),
        .evt_fw    (evt_fw),
        .held_info (sts_info),
        .held_cnt  (sts_cnt),
        .cap_field (cap_field),
        .rd_field  (rd_field)
    );

    // Status word: capture, keep-first, count, clear; event beats clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sts_valid <= 1'b0;
            sts_code  <= '0;
            sts_info  <= '0;
            sts_cnt   <= '0;
            fault_q   <= 1'b0;
        end else begin
            fault_q <= sts_bad;
            if (fire) begin
                if (!keep_valid) begin
                    sts_valid      <= 1'b1;
                    sts_code.arch  <= sel_arch;
                    sts_code.model <= sel_model;
                    sts_info       <= cap_field;
                    sts_cnt        <= corr_sel ? CNT_W'(1) : '0;
                end else if (corr_sel && (sts_cnt != CNT_MAX)) begin
                    sts_cnt <= sts_cnt + CNT_W'(1);
                end
            end else if (sts_clr) begin
                sts_valid <= 1'b0;
                sts_code  <= '0;
                sts_info  <= '0;
                sts_cnt   <= '0;
            end
        end
    end

    // Read mux for the selected register
    always_comb begin
        if (reg_sel == SEL_CTL) begin
            reg_rdata = REG_W'(ctl);
        end else begin
            reg_rdata = {sts_valid, {PAD_W{1'b0}}, rd_field, sts_code};
        end
    end

    assign wr_fault = fault_q;

    // R5: no grant reaches a disabled source
    a_r5_grant_enabled: assert property (@(posedge clk) disable iff (!rst_n)
        ((grant & ~ctl) == '0));
    // R12: at most one source is granted
    a_r12_one_grant: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));
    // R3: a refused write raises the fault on the next cycle
    a_r3_fault_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        sts_bad |=> wr_fault);
    // R3: a refused write with no event leaves the status word alone
    a_r3_status_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (sts_bad && !fire) |=> ($stable(sts_valid) && $stable(sts_code) && $stable(sts_cnt)));
    // R4: a lone clear empties the word and the counter
    a_r4_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
        (sts_clr && !fire) |=> (!sts_valid && (sts_cnt == '0)));
    // R10: a later event keeps the first codes
    a_r10_keep_first: assert property (@(posedge clk) disable iff (!rst_n)
        (sts_valid && fire && !sts_clr) |=> $stable(sts_code));
    // R10: the counter stays at its ceiling
    a_r10_saturate: assert property (@(posedge clk) disable iff (!rst_n)
        (sts_valid && !sts_clr && (sts_cnt == CNT_MAX)) |=> (sts_cnt == CNT_MAX));
    // R11: an event colliding with a clear leaves the word valid
    a_r11_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && sts_clr) |=> sts_valid);
endmodule

// File: tb/mc_err_bank_tb.sv
// Bench: sweeps all sources and all capability combinations, with
// expected status words computed field by field from the requirements.
module mc_err_bank_tb;
    localparam int N = 64;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            cap_cnt = 0, cap_thr = 0, cap_ext = 0, cap_fw = 0, legacy_ctl = 0;
    logic [N-1:0]    src_req = '0, src_corr = '0;
    logic [N*16-1:0] src_arch, src_model;
    logic [24:0]     evt_info = '0;
    logic [1:0]      evt_thr = '0;
    logic            evt_fw = 0;
    logic            reg_we = 0, reg_sel = 0;
    logic [63:0]     reg_wdata = '0;
    logic [63:0]     reg_rdata;
    logic            wr_fault;
    int              checks = 0, errors = 0;
    logic [63:0]     rv;

    always #5 clk = ~clk;

    mc_err_bank #(.NUM_SRC(N)) u_dut (
        .clk(clk), .rst_n(rst_n), .cap_cnt(cap_cnt), .cap_thr(cap_thr),
        .cap_ext(cap_ext), .cap_fw(cap_fw), .legacy_ctl(legacy_ctl),
        .src_req(src_req), .src_corr(src_corr), .src_arch(src_arch),
        .src_model(src_model), .evt_info(evt_info), .evt_thr(evt_thr),
        .evt_fw(evt_fw), .reg_we(reg_we), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .wr_fault(wr_fault)
    );

    function automatic logic [15:0] arch_of(int k);
        return 16'(k * 37 + 5);
    endfunction

    function automatic logic [15:0] model_of(int k);
        return 16'hC000 ^ 16'(k * 3);
    endfunction

    // Expected status word from the layout rules R2, R7, R8, R9
    function automatic logic [63:0] exp_sts(int k, logic [24:0] info, logic [1:0] thr,
                                            logic fw, logic [14:0] cnt, logic c_cnt,
                                            logic c_thr, logic c_ext, logic c_fw);
        logic [24:0] up;
        up = info;
        if (c_fw) up[5] = fw;
        if (c_cnt) up[20:6] = cnt;
        if (c_thr) begin
            up[22:21] = thr;
            if (!c_ext) up[24:23] = 2'b00;
        end
        return {1'b1, 6'b0, up, model_of(k), arch_of(k)};
    endfunction

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic rd(logic sel, output logic [63:0] val);
        reg_sel = sel;
        #1;
        val = reg_rdata;
    endtask

    task automatic wr(logic sel, logic [63:0] data);
        @(negedge clk);
        reg_we = 1; reg_sel = sel; reg_wdata = data;
        @(negedge clk);
        reg_we = 0; reg_wdata = '0;
    endtask

    task automatic pulse(logic [N-1:0] req, logic [N-1:0] corr);
        @(negedge clk);
        src_req = req; src_corr = corr;
        @(negedge clk);
        src_req = '0; src_corr = '0;
    endtask

    initial begin
        for (int k = 0; k < N; k++) begin
            src_arch[k*16 +: 16]  = arch_of(k);
            src_model[k*16 +: 16] = model_of(k);
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        rd(0, rv); chk("R1 control", rv, 64'h0);
        rd(1, rv); chk("R1 status", rv, 64'h0);
        chk("R1 fault", {63'h0, wr_fault}, 64'h0);

        // R6 free write when not in legacy mode
        wr(0, 64'h0123_4567_89AB_CDEF);
        rd(0, rv); chk("R6 free write", rv, 64'h0123_4567_89AB_CDEF);

        // R5 sweep: one enable bit, every source requests
        for (int j = 0; j < N; j++) begin
            wr(0, 64'h1 << j);
            pulse('1, '0);
            rd(1, rv); chk($sformatf("R5 single enable %0d", j), rv, exp_sts(j, '0, 0, 0, 0, 0, 0, 0, 0));
            wr(1, 64'h0);
        end

        // R12 / R2 sweep: all enabled, requests from j upward
        wr(0, '1);
        for (int j = 0; j < N; j++) begin
            pulse(~((N'(1) << j) - N'(1)), '0);
            rd(1, rv); chk($sformatf("R12 lowest index %0d", j), rv, exp_sts(j, '0, 0, 0, 0, 0, 0, 0, 0));
            wr(1, 64'h0);
        end

        // R5 disabled sources log nothing
        wr(0, ~(64'h1 << 3));
        pulse(N'(1) << 3, '0);
        rd(1, rv); chk("R5 disabled source", rv, 64'h0);
        wr(0, 64'h0);
        pulse('1, '1);
        rd(1, rv); chk("R5 all disabled", rv, 64'h0);

        // R7 R8 R9 layout across every capability combination
        wr(0, '1);
        evt_info = 25'h15A_5A5A; evt_thr = 2'b10; evt_fw = 1'b1;
        for (int c = 0; c < 16; c++) begin
            cap_cnt = c[0]; cap_thr = c[1]; cap_ext = c[2]; cap_fw = c[3];
            pulse(N'(1) << 7, N'(1) << 7);
            rd(1, rv);
            chk($sformatf("R7 R8 R9 layout caps=%0d", c), rv,
                exp_sts(7, 25'h15A_5A5A, 2'b10, 1'b1, 15'd1, c[0], c[1], c[2], c[3]));
            wr(1, 64'h0);
        end
        evt_info = '0; evt_thr = '0; evt_fw = 0;
        cap_cnt = 1; cap_thr = 0; cap_ext = 0; cap_fw = 0;

        // R10 first event kept, counter advances on corrected events
        pulse(N'(1) << 2, N'(1) << 2);
        pulse(N'(1) << 1, N'(1) << 1);
        rd(1, rv); chk("R10 keep first count 2", rv, exp_sts(2, '0, 0, 0, 15'd2, 1, 0, 0, 0));
        pulse(N'(1) << 0, '0);
        rd(1, rv); chk("R10 uncorrected no count", rv, exp_sts(2, '0, 0, 0, 15'd2, 1, 0, 0, 0));

        // R3 nonzero status write refused, fault for one cycle
        wr(1, 64'h1);
        chk("R3 fault high", {63'h0, wr_fault}, 64'h1);
        rd(1, rv); chk("R3 status kept", rv, exp_sts(2, '0, 0, 0, 15'd2, 1, 0, 0, 0));
        @(negedge clk);
        chk("R3 fault one cycle", {63'h0, wr_fault}, 64'h0);

        // R10 saturation under a long corrected stream
        @(negedge clk);
        src_req = N'(1) << 4; src_corr = N'(1) << 4;
        repeat (32800) @(negedge clk);
        src_req = '0; src_corr = '0;
        rd(1, rv); chk("R10 saturate", rv, exp_sts(2, '0, 0, 0, 15'h7FFF, 1, 0, 0, 0));

        // R11 clear and event in the same cycle
        @(negedge clk);
        reg_we = 1; reg_sel = 1; reg_wdata = '0; src_req = N'(1) << 9;
        @(negedge clk);
        reg_we = 0; src_req = '0;
        rd(1, rv); chk("R11 event wins", rv, exp_sts(9, '0, 0, 0, 15'd0, 1, 0, 0, 0));
        chk("R11 no fault", {63'h0, wr_fault}, 64'h0);

        // R4 zero write clears
        wr(1, 64'h0);
        rd(1, rv); chk("R4 cleared", rv, 64'h0);
        chk("R4 no fault", {63'h0, wr_fault}, 64'h0);

        // R6 legacy filter
        legacy_ctl = 1;
        wr(0, '1);
        wr(0, 64'h5);
        rd(0, rv); chk("R6 legacy mixed ignored", rv, '1);
        wr(0, 64'h0);
        rd(0, rv); chk("R6 legacy zeros", rv, 64'h0);
        wr(0, '1);
        rd(0, rv); chk("R6 legacy ones", rv, '1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule